// File: doc/BRIEF.md
# Directory-Protocol Cache Line Controller

This block is the cache-side controller of one processing node in a directory-based coherence scheme. It owns a small direct-mapped cache. Each line holds one data word, an address tag and a coherence state: Invalid, Shared or Exclusive. The processor issues loads and stores through a request port that has a stall signal. Every access that the resident line cannot satisfy turns into an explicit message to the home directory, and the processor stays stalled until the reply has filled the line and the access has completed.

Coherence actions from the directory arrive as addressed messages on an inbound port, not as snooped bus traffic: invalidate, fetch, fetch-and-invalidate, and the data reply that ends a miss. Every command gets a response on the single outbound port in the next cycle. The response is either a write-back that carries the line's data or a plain acknowledge. The outbound port also carries read-miss requests, write-miss requests and eviction write-backs. It has no backpressure: each message is one single-cycle pulse.

Top module: `dcc_ctrl`

## Requirements
- R1: After reset every line is Invalid, `out_valid` is 0, and `cpu_stall` is 0 while `cpu_req` is 0.
- R2: A load whose line holds the same tag in Shared or Exclusive completes in its request cycle: `cpu_stall` is 0, `cpu_rdata` returns the line's word, and no outbound message follows.
- R3: A load that misses raises `cpu_stall`. In the next cycle it sends a read miss (`out_kind` 0) carrying the load address. The stall holds until a data reply (`in_kind` 3) arrives with that address. That reply fills the line as Shared with the reply data. The load then completes in the cycle after the reply, returning the reply data.
- R4: A store whose line is not Exclusive with the same tag is a write miss, even when the line is Shared with the same tag. In the next cycle it sends `out_kind` 1 with the store address.
- R5: The data reply to a write miss fills the line as Exclusive, with the pending store word in place of the reply data. The stall is released in the cycle after the reply.
- R6: A store to a line that is Exclusive with the same tag completes in its request cycle, writes the word, and sends nothing.
- R7: A miss whose line is Exclusive under a different tag first sends a write-back (`out_kind` 2) with the old block's address and data, and the line becomes Invalid. The miss request follows in the next cycle.
- R8: An invalidate (`in_kind` 0) addressed to a resident Shared line makes it Invalid. In the next cycle the controller sends an acknowledge (`out_kind` 3) carrying the message address.
- R9: A fetch (`in_kind` 1) addressed to a resident Exclusive line causes a write-back of its word in the next cycle, and the line becomes Shared.
- R10: A fetch-and-invalidate (`in_kind` 2) addressed to a resident Exclusive line causes a write-back of its word in the next cycle, and the line becomes Invalid.
- R11: A command whose tag does not match the resident line, or whose line is not in the state the command acts on, causes an acknowledge with the message address in the next cycle and leaves the line unchanged.
- R12: In a cycle with `in_valid` high, a pending CPU request is stalled and the CPU side sends nothing, so the inbound message alone uses the outbound port in the next cycle.
- R13: A data reply that arrives while no miss is outstanding, or whose address differs from the outstanding miss, is dropped: nothing is sent and no line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until the stall drops |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Access address: low log2(NLINES) bits index the line, the rest form the tag |
| cpu_wdata | input | DW | Store data |
| cpu_rdata | output | DW | Word of the indexed line |
| cpu_stall | output | 1 | Request not completed in this cycle |
| in_valid | input | 1 | Inbound message present |
| in_kind | input | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| in_addr | input | AW | Block address of the inbound message |
| in_data | input | DW | Reply data |
| out_valid | output | 1 | Outbound message pulse |
| out_kind | output | 2 | 0 read miss, 1 write miss, 2 write-back, 3 acknowledge |
| out_addr | output | AW | Block address of the outbound message |
| out_data | output | DW | Write-back data, 0 otherwise |

## Verification
Directed sequences walk one index through each transition in turn. A read miss fills the line Shared, a store to it upgrades it, and a store hit follows. A conflicting block then evicts the line, and each command kind is applied once to the state it acts on and once to a state it does not. Comparing a Shared same-tag store with an Exclusive one separates the upgrade path from a true hit. Sending a fetch to a Shared line and an invalidate to an absent tag separates the acting case from the acknowledge-only case. A reply sent while idle shows that stray data cannot create a line. Random traffic over three tags and four indexes then mixes loads, stores, commands and varied reply delays. This exercises evictions of dirty lines and commands that race with resident lines, and every result is compared against a bench model of the lines and of home memory.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SH  = 2'd1,
    LS_EX  = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    IN_INVAL     = 2'd0,
    IN_FETCH     = 2'd1,
    IN_FETCH_INV = 2'd2,
    IN_REPLY     = 2'd3
  } in_kind_e;

  typedef enum logic [1:0] {
    OUT_RD_MISS = 2'd0,
    OUT_WR_MISS = 2'd1,
    OUT_WRBACK  = 2'd2,
    OUT_ACK     = 2'd3
  } out_kind_e;
endpackage

// File: rtl/dcc_line_store.sv
`timescale 1ns/1ps
module dcc_line_store
  import dcc_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int IDXW   = 2,
  parameter int TAGW   = 6,
  parameter int DW     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] ra_idx,
  output line_st_e        ra_st,
  output logic [TAGW-1:0] ra_tag,
  output logic [DW-1:0]   ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output line_st_e        rb_st,
  output logic [TAGW-1:0] rb_tag,
  output logic [DW-1:0]   rb_data,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  line_st_e        wr_st,
  input  logic [TAGW-1:0] wr_tag,
  input  logic [DW-1:0]   wr_data
);
  line_st_e        st_q  [NLINES];
  logic [TAGW-1:0] tag_q [NLINES];
  logic [DW-1:0]   dat_q [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NLINES; k++) begin
        st_q[k]  <= LS_INV;
        tag_q[k] <= '0;
        dat_q[k] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]  <= wr_st;
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assign ra_st   = st_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign ra_data = dat_q[ra_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_data = dat_q[rb_idx];
endmodule

// File: rtl/dcc_inbound.sv
`timescale 1ns/1ps
module dcc_inbound
  import dcc_pkg::*;
#(
  parameter int TAGW = 6,
  parameter int DW   = 16
) (
  input  logic            msg_valid,
  input  in_kind_e        msg_kind,
  input  logic [TAGW-1:0] msg_tag,
  input  line_st_e        ln_st,
  input  logic [TAGW-1:0] ln_tag,
  input  logic [DW-1:0]   ln_data,
  output logic            upd_en,
  output line_st_e        upd_st,
  output logic            rsp_en,
  output out_kind_e       rsp_kind,
  output logic [DW-1:0]   rsp_data,
  output logic            ev_inval_hit,
  output logic            ev_fetch_hit,
  output logic            ev_fetch_inv_hit,
  output logic            ev_nomatch
);
  logic resident;
  logic is_cmd;
  logic give_data;

  assign resident = (ln_st != LS_INV) && (ln_tag == msg_tag);
  assign is_cmd   = msg_valid && (msg_kind != IN_REPLY);

  assign ev_inval_hit     = is_cmd && msg_kind == IN_INVAL     && resident && ln_st == LS_SH;
  assign ev_fetch_hit     = is_cmd && msg_kind == IN_FETCH     && resident && ln_st == LS_EX;
  assign ev_fetch_inv_hit = is_cmd && msg_kind == IN_FETCH_INV && resident && ln_st == LS_EX;
  assign ev_nomatch       = is_cmd && !(ev_inval_hit || ev_fetch_hit || ev_fetch_inv_hit);

  assign give_data = ev_fetch_hit || ev_fetch_inv_hit;
  assign upd_en    = ev_inval_hit || give_data;
  assign upd_st    = ev_fetch_hit ? LS_SH : LS_INV;
  assign rsp_en    = is_cmd;
  assign rsp_kind  = give_data ? OUT_WRBACK : OUT_ACK;
  assign rsp_data  = give_data ? ln_data : '0;
endmodule

// File: rtl/dcc_miss_fsm.sv
`timescale 1ns/1ps
module dcc_miss_fsm
  import dcc_pkg::*;
#(
  parameter int AW   = 8,
  parameter int IDXW = 2,
  parameter int TAGW = 6,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic            cpu_hit,
  input  line_st_e        ln_st,
  input  logic [TAGW-1:0] ln_tag,
  input  logic [DW-1:0]   ln_data,
  input  logic            in_valid,
  input  in_kind_e        in_kind,
  input  logic [AW-1:0]   in_addr,
  input  logic [DW-1:0]   in_data,
  output logic            send_en,
  output out_kind_e       send_kind,
  output logic [AW-1:0]   send_addr,
  output logic [DW-1:0]   send_data,
  output logic            upd_en,
  output logic [IDXW-1:0] upd_idx,
  output line_st_e        upd_st,
  output logic [TAGW-1:0] upd_tag,
  output logic [DW-1:0]   upd_data,
  output logic            waiting,
  output logic            ev_victim_wb,
  output logic            ev_fill
);
  typedef enum logic {F_IDLE = 1'b0, F_WAIT = 1'b1} fsm_e;

  fsm_e          state_q;
  logic [AW-1:0] pend_addr_q;
  logic          pend_we_q;
  logic [DW-1:0] pend_wdata_q;
  logic          start;
  logic          issue;

  assign waiting      = (state_q == F_WAIT);
  assign start        = (state_q == F_IDLE) && cpu_req && !cpu_hit && !in_valid;
  assign ev_victim_wb = start && ln_st == LS_EX && ln_tag != cpu_addr[AW-1:IDXW];
  assign issue        = start && !ev_victim_wb;
  assign ev_fill      = waiting && in_valid && in_kind == IN_REPLY && in_addr == pend_addr_q;

  assign send_en   = ev_victim_wb || issue;
  assign send_kind = ev_victim_wb ? OUT_WRBACK : (cpu_we ? OUT_WR_MISS : OUT_RD_MISS);
  assign send_addr = ev_victim_wb ? {ln_tag, cpu_addr[IDXW-1:0]} : cpu_addr;
  assign send_data = ev_victim_wb ? ln_data : '0;

  assign upd_en   = ev_victim_wb || ev_fill;
  assign upd_idx  = ev_fill ? pend_addr_q[IDXW-1:0] : cpu_addr[IDXW-1:0];
  assign upd_st   = ev_fill ? (pend_we_q ? LS_EX : LS_SH) : LS_INV;
  assign upd_tag  = ev_fill ? pend_addr_q[AW-1:IDXW] : ln_tag;
  assign upd_data = ev_fill ? (pend_we_q ? pend_wdata_q : in_data) : ln_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= F_IDLE;
      pend_addr_q  <= '0;
      pend_we_q    <= 1'b0;
      pend_wdata_q <= '0;
    end else if (issue) begin
      state_q      <= F_WAIT;
      pend_addr_q  <= cpu_addr;
      pend_we_q    <= cpu_we;
      pend_wdata_q <= cpu_wdata;
    end else if (ev_fill) begin
      state_q <= F_IDLE;
    end
  end
endmodule

// File: rtl/dcc_ctrl.sv
`timescale 1ns/1ps
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int NLINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_stall,
  input  logic          in_valid,
  input  logic [1:0]    in_kind,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [1:0]    out_kind,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  localparam int IDXW = $clog2(NLINES);
  localparam int TAGW = AW - IDXW;

  function automatic logic [IDXW-1:0] idx_of(input logic [AW-1:0] a);
    return a[IDXW-1:0];
  endfunction

  function automatic logic [TAGW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IDXW];
  endfunction

  function automatic logic grants(input line_st_e st, input logic we);
    return we ? (st == LS_EX) : (st != LS_INV);
  endfunction

  in_kind_e        in_kind_t;
  line_st_e        ln_a_st, ln_b_st;
  logic [TAGW-1:0] ln_a_tag, ln_b_tag;
  logic [DW-1:0]   ln_a_data, ln_b_data;

  logic            ib_upd_en, ib_rsp_en;
  line_st_e        ib_upd_st;
  out_kind_e       ib_rsp_kind;
  logic [DW-1:0]   ib_rsp_data;
  logic            ev_inval_hit, ev_fetch_hit, ev_fetch_inv_hit, ev_nomatch;

  logic            fsm_send_en, fsm_upd_en, fsm_wait, ev_victim_wb, ev_fill;
  out_kind_e       fsm_send_kind;
  logic [AW-1:0]   fsm_send_addr;
  logic [DW-1:0]   fsm_send_data;
  logic [IDXW-1:0] fsm_upd_idx;
  line_st_e        fsm_upd_st;
  logic [TAGW-1:0] fsm_upd_tag;
  logic [DW-1:0]   fsm_upd_data;

  logic            cpu_hit, cpu_wr_hit;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  line_st_e        wr_st;
  logic [TAGW-1:0] wr_tag;
  logic [DW-1:0]   wr_data;

  assign in_kind_t = in_kind_e'(in_kind);

  dcc_line_store #(.NLINES(NLINES), .IDXW(IDXW), .TAGW(TAGW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(idx_of(cpu_addr)), .ra_st(ln_a_st), .ra_tag(ln_a_tag), .ra_data(ln_a_data),
    .rb_idx(idx_of(in_addr)), .rb_st(ln_b_st), .rb_tag(ln_b_tag), .rb_data(ln_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  dcc_inbound #(.TAGW(TAGW), .DW(DW)) u_inbound (
    .msg_valid(in_valid), .msg_kind(in_kind_t), .msg_tag(tag_of(in_addr)),
    .ln_st(ln_b_st), .ln_tag(ln_b_tag), .ln_data(ln_b_data),
    .upd_en(ib_upd_en), .upd_st(ib_upd_st),
    .rsp_en(ib_rsp_en), .rsp_kind(ib_rsp_kind), .rsp_data(ib_rsp_data),
    .ev_inval_hit(ev_inval_hit), .ev_fetch_hit(ev_fetch_hit),
    .ev_fetch_inv_hit(ev_fetch_inv_hit), .ev_nomatch(ev_nomatch)
  );

  dcc_miss_fsm #(.AW(AW), .IDXW(IDXW), .TAGW(TAGW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_hit(cpu_hit), .ln_st(ln_a_st), .ln_tag(ln_a_tag), .ln_data(ln_a_data),
    .in_valid(in_valid), .in_kind(in_kind_t), .in_addr(in_addr), .in_data(in_data),
    .send_en(fsm_send_en), .send_kind(fsm_send_kind), .send_addr(fsm_send_addr),
    .send_data(fsm_send_data),
    .upd_en(fsm_upd_en), .upd_idx(fsm_upd_idx), .upd_st(fsm_upd_st),
    .upd_tag(fsm_upd_tag), .upd_data(fsm_upd_data),
    .waiting(fsm_wait), .ev_victim_wb(ev_victim_wb), .ev_fill(ev_fill)
  );

  assign cpu_hit    = cpu_req && !fsm_wait && ln_a_tag == tag_of(cpu_addr) &&
                      grants(ln_a_st, cpu_we);
  assign cpu_wr_hit = cpu_hit && cpu_we && !in_valid;
  assign cpu_stall  = cpu_req && (in_valid || !cpu_hit);
  assign cpu_rdata  = ln_a_data;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = idx_of(cpu_addr);
    wr_st   = LS_EX;
    wr_tag  = tag_of(cpu_addr);
    wr_data = cpu_wdata;
    if (ib_upd_en) begin
      wr_en   = 1'b1;
      wr_idx  = idx_of(in_addr);
      wr_st   = ib_upd_st;
      wr_tag  = ln_b_tag;
      wr_data = ln_b_data;
    end else if (fsm_upd_en) begin
      wr_en   = 1'b1;
      wr_idx  = fsm_upd_idx;
      wr_st   = fsm_upd_st;
      wr_tag  = fsm_upd_tag;
      wr_data = fsm_upd_data;
    end else if (cpu_wr_hit) begin
      wr_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= 2'd0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (ib_rsp_en) begin
      out_valid <= 1'b1;
      out_kind  <= ib_rsp_kind;
      out_addr  <= in_addr;
      out_data  <= ib_rsp_data;
    end else if (fsm_send_en) begin
      out_valid <= 1'b1;
      out_kind  <= fsm_send_kind;
      out_addr  <= fsm_send_addr;
      out_data  <= fsm_send_data;
    end else begin
      out_valid <= 1'b0;
      out_kind  <= 2'd0;
      out_addr  <= '0;
      out_data  <= '0;
    end
  end
endmodule

// File: rtl/dcc_ctrl_chk.sv
`timescale 1ns/1ps
module dcc_ctrl_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_stall,
  input logic [AW-1:0] cpu_addr,
  input logic          in_valid,
  input logic [1:0]    in_kind,
  input logic [AW-1:0] in_addr,
  input logic          out_valid,
  input logic [1:0]    out_kind,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data,
  input logic [DW-1:0] ln_b_data,
  input logic          ev_inval_hit,
  input logic          ev_fetch_hit,
  input logic          ev_fetch_inv_hit,
  input logic          ev_nomatch,
  input logic          ev_victim_wb,
  input logic          fsm_wait
);
  assert_wait_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_wait && cpu_req |-> cpu_stall);

  assert_victim_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_victim_wb |=> out_valid && out_kind == 2'd2 && out_addr != $past(cpu_addr));

  assert_inval_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inval_hit |=> out_valid && out_kind == 2'd3);

  assert_fetch_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_hit |=> out_valid && out_kind == 2'd2 && out_data == $past(ln_b_data));

  assert_fetch_inv_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_inv_hit |=> out_valid && out_kind == 2'd2 && out_data == $past(ln_b_data));

  assert_nomatch_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nomatch |=> out_valid && out_kind == 2'd3 && out_addr == $past(in_addr));

  assert_inbound_stalls_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cpu_req |-> cpu_stall);

  assert_reply_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == 2'd3 |=> !out_valid);
endmodule

bind dcc_ctrl dcc_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_stall(cpu_stall), .cpu_addr(cpu_addr),
  .in_valid(in_valid), .in_kind(in_kind), .in_addr(in_addr),
  .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data),
  .ln_b_data(ln_b_data), .ev_inval_hit(ev_inval_hit), .ev_fetch_hit(ev_fetch_hit),
  .ev_fetch_inv_hit(ev_fetch_inv_hit), .ev_nomatch(ev_nomatch),
  .ev_victim_wb(ev_victim_wb), .fsm_wait(fsm_wait)
);

// File: tb/dcc_ctrl_bench.sv
`timescale 1ns/1ps
module dcc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic        cpu_stall;
  logic        in_valid;
  logic [1:0]  in_kind;
  logic [7:0]  in_addr;
  logic [15:0] in_data;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [7:0]  out_addr;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;

  // bench model: state 0 Invalid, 1 Shared, 2 Exclusive
  int          m_st   [4];
  logic [5:0]  m_tag  [4];
  logic [15:0] m_data [4];
  logic [15:0] bmem   [256];

  always #5 clk = ~clk;

  dcc_ctrl u_dcc_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .in_valid(in_valid), .in_kind(in_kind), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data)
  );

  function automatic logic [15:0] home_val(input logic [7:0] a);
    return 16'(a * 37) ^ 16'h5A00;
  endfunction

  function automatic bit model_hit(input logic we, input logic [7:0] a);
    int i = int'(a[1:0]);
    if (m_st[i] == 0 || m_tag[i] != a[7:2]) return 1'b0;
    return we ? (m_st[i] == 2) : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_access(input logic we, input logic [7:0] a, input logic [15:0] wd, input int gap);
    int i = int'(a[1:0]);
    bit victim;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    if (model_hit(we, a)) begin
      chk(cpu_stall == 1'b0, we ? "R6 store hit stall" : "R2 load hit stall", 32'(cpu_stall), 0);
      if (!we) chk(cpu_rdata == m_data[i], "R2 load hit data", 32'(cpu_rdata), 32'(m_data[i]));
      @(negedge clk);
      cpu_req = 1'b0;
      chk(out_valid == 1'b0, we ? "R6 no message" : "R2 no message", 32'(out_valid), 0);
      if (we) m_data[i] = wd;
    end else begin
      chk(cpu_stall == 1'b1, we ? "R4 miss stall" : "R3 miss stall", 32'(cpu_stall), 1);
      victim = (m_st[i] == 2) && (m_tag[i] != a[7:2]);
      @(negedge clk);
      if (victim) begin
        chk(out_valid && out_kind == 2'd2, "R7 write-back kind", {out_valid, out_kind}, 32'h6);
        chk(out_addr == {m_tag[i], a[1:0]}, "R7 write-back addr", 32'(out_addr), 32'({m_tag[i], a[1:0]}));
        chk(out_data == m_data[i], "R7 write-back data", 32'(out_data), 32'(m_data[i]));
        bmem[{m_tag[i], a[1:0]}] = m_data[i];
        m_st[i] = 0;
        @(negedge clk);
      end
      chk(out_valid && out_kind == {1'b0, we}, we ? "R4 write miss kind" : "R3 read miss kind",
          {out_valid, out_kind}, {29'd0, 1'b1, 1'b0, we});
      chk(out_addr == a, we ? "R4 miss addr" : "R3 miss addr", 32'(out_addr), 32'(a));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(!out_valid && cpu_stall, "R3 held while waiting", {out_valid, cpu_stall}, 32'h1);
      end
      @(negedge clk);
      in_valid = 1'b1; in_kind = 2'd3; in_addr = a; in_data = bmem[a];
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      m_st[i] = we ? 2 : 1; m_tag[i] = a[7:2]; m_data[i] = we ? wd : bmem[a];
      chk(cpu_stall == 1'b0, we ? "R5 release after reply" : "R3 release after reply", 32'(cpu_stall), 0);
      chk(cpu_rdata == m_data[i], we ? "R5 store applied" : "R3 fill data", 32'(cpu_rdata), 32'(m_data[i]));
      chk(out_valid == 1'b0, "R13 reply sends nothing", 32'(out_valid), 0);
      @(negedge clk);
      cpu_req = 1'b0;
    end
  endtask

  task automatic inbound(input logic [1:0] kind, input logic [7:0] a);
    int i = int'(a[1:0]);
    bit res = (m_st[i] != 0) && (m_tag[i] == a[7:2]);
    bit act;
    string req;
    act = (kind == 2'd0) ? (res && m_st[i] == 1) : (res && m_st[i] == 2);
    req = !act ? "R11" : (kind == 2'd0) ? "R8" : (kind == 2'd1) ? "R9" : "R10";
    @(negedge clk);
    cpu_req = 1'b0;
    in_valid = 1'b1; in_kind = kind; in_addr = a; in_data = 16'hDEAD;
    @(negedge clk);
    in_valid = 1'b0;
    if (act && kind != 2'd0) begin
      chk(out_valid && out_kind == 2'd2, {req, " write-back kind"}, {out_valid, out_kind}, 32'h6);
      chk(out_data == m_data[i], {req, " write-back data"}, 32'(out_data), 32'(m_data[i]));
      bmem[a] = m_data[i];
      m_st[i] = (kind == 2'd1) ? 1 : 0;
    end else begin
      chk(out_valid && out_kind == 2'd3, {req, " ack kind"}, {out_valid, out_kind}, 32'h7);
      if (act) m_st[i] = 0;
    end
    chk(out_addr == a, {req, " response addr"}, 32'(out_addr), 32'(a));
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd611));
    for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_tag[k] = '0; m_data[k] = '0; end
    for (int k = 0; k < 256; k++) bmem[k] = home_val(8'(k));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    in_valid = 1'b0; in_kind = '0; in_addr = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && !cpu_stall, "R1 reset outputs", {out_valid, cpu_stall}, 0);

    cpu_access(1'b0, 8'h04, 16'h0, 2);     // R1 line empty, R3 read miss fill
    cpu_access(1'b0, 8'h04, 16'h0, 0);     // R2 read hit
    cpu_access(1'b1, 8'h04, 16'hBEEF, 1);  // R4 upgrade of Shared, R5 store applied
    cpu_access(1'b1, 8'h04, 16'h1234, 0);  // R6 store hit
    cpu_access(1'b0, 8'h04, 16'h0, 0);     // R6 data visible
    cpu_access(1'b0, 8'h08, 16'h0, 1);     // R7 dirty victim
    inbound(2'd0, 8'h08);                  // R8 invalidate Shared
    cpu_access(1'b0, 8'h08, 16'h0, 0);     // R8 line gone, miss again
    cpu_access(1'b1, 8'h05, 16'hA5A5, 0);  // R5 write miss fill
    inbound(2'd1, 8'h05);                  // R9 fetch
    cpu_access(1'b0, 8'h05, 16'h0, 0);     // R9 now Shared: read hit
    cpu_access(1'b1, 8'h05, 16'h0F0F, 2);  // R4 upgrade again
    inbound(2'd2, 8'h05);                  // R10 fetch-invalidate
    cpu_access(1'b0, 8'h05, 16'h0, 0);     // R10 line Invalid: miss
    inbound(2'd1, 8'h08);                  // R11 fetch on Shared
    inbound(2'd0, 8'h0C);                  // R11 tag absent
    cpu_access(1'b0, 8'h08, 16'h0, 0);     // R11 unchanged: hit

    // R12: load hit held off by a simultaneous inbound message
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h08;
    in_valid = 1'b1; in_kind = 2'd0; in_addr = 8'h0D; in_data = '0;
    #1;
    chk(cpu_stall == 1'b1, "R12 stall during inbound", 32'(cpu_stall), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid && out_kind == 2'd3 && out_addr == 8'h0D, "R12 inbound owns port",
        {out_valid, out_kind, out_addr}, {21'd0, 1'b1, 2'd3, 8'h0D});
    chk(cpu_stall == 1'b0 && cpu_rdata == m_data[0], "R12 load completes after",
        {cpu_stall, cpu_rdata}, {15'd0, 1'b0, m_data[0]});
    @(negedge clk);
    cpu_req = 1'b0;

    // R13: stray reply while idle
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd3; in_addr = 8'h0A; in_data = 16'h7777;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R13 stray reply silent", 32'(out_valid), 0);
    cpu_access(1'b0, 8'h0A, 16'h0, 0);     // R13 line still Invalid: miss

    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom % 10);
      logic [7:0] a = 8'((($urandom % 3) << 2) | ($urandom % 4));
      if (r < 6) cpu_access(r < 3, a, 16'($urandom), int'($urandom % 3));
      else inbound(2'($urandom % 3), a);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule